// File: doc/BRIEF.md
# System Control Register Bank

This block is a 32-bit register bank that sits on a simple memory-mapped bus with a select, a write enable, a 12-bit byte address, write data and read data. It decodes a 4 KB window. Behind this bus it holds an LED output register, a debug control word, a general-purpose control word, synchronised button and switch inputs, and two free-running time counters. The time counters advance once per second and a hundred times per second. Both are derived from the system clock by integer dividers. The bus side of a separate prescaled counter pair is also decoded here. Writes to that pair's three offsets are forwarded as strobes with the write data, and reads return the values the pair supplies.

Reads are combinational during the select cycle. Writes take effect at the clock edge that ends the select cycle. The debug word and the switch inputs are present only when their parameters enable them; otherwise their offsets behave like holes in the map. Every access to a hole raises a one-cycle flag for test observation. Reset is active low and synchronous to the clock.

Top module: `sysctl_regbank`

## Requirements
- R1: The byte offsets are fixed: LED 0x00, debug 0x04, buttons 0x08, 1 Hz counter 0x10, 100 Hz counter 0x14, prescaled count 0x18, prescale reload 0x1C, prescale down-counter 0x20, switches 0x28, control word 0x4C. Only exact word offsets match.
- R2: A write to 0x00 stores the low NUM_LEDS bits of the data, and bit i drives `leds[i]`. A read returns the stored bits zero-extended. With NUM_LEDS = 0, the write has no effect and the read returns 0.
- R3: The control word at 0x4C, and the debug word at 0x04 when HAS_DBGCTRL = 1, read back the full 32-bit value last written.
- R4: An offset that matches nothing reads as 0 and ignores writes. This includes 0x04 when HAS_DBGCTRL = 0, 0x28 when HAS_SWITCHES = 0, and unaligned offsets. `badAccess` is high in the select cycle of such an access, and only then.
- R5: A read of 0x08 returns the button inputs zero-extended. A read of 0x28 returns the switch inputs zero-extended. Each passes through a two-register synchroniser, so a change is visible on the second clock edge after it. Writes to these offsets change nothing.
- R6: The 100 Hz counter increases by one every CLK_HZ/100 clock edges. With n edges since reset, it reads floor(n / (CLK_HZ/100)).
- R7: The 1 Hz counter increases by one every CLK_HZ clock edges. With n edges since reset, it reads floor(n / CLK_HZ).
- R8: Writing V to either time counter loads V and restarts its divider. k edges after the loading edge, it reads V + floor(k / divisor), modulo 2^32.
- R9: A write to 0x18, 0x1C or 0x20 raises, during that cycle only, `pcCounterWr`, `pcPrescaleWr` or `pcPscntrWr` respectively, with `pcWdata` equal to the bus data. Reads of these offsets return `pcCounterVal`, `pcPrescaleVal` and `pcPscntrVal`.
- R10: After reset, the LED, debug and control words and both time counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| psel | input | 1 | Bus select for this window |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when not reading |
| buttons | input | NUM_BUTTONS | Asynchronous button inputs |
| switches | input | NUM_SWITCHES | Asynchronous switch inputs |
| leds | output | max(NUM_LEDS,1) | LED drive, bit i from stored bit i |
| pcCounterWr | output | 1 | Write strobe, prescaled count |
| pcPrescaleWr | output | 1 | Write strobe, prescale reload |
| pcPscntrWr | output | 1 | Write strobe, prescale down-counter |
| pcWdata | output | 32 | Data for the prescaled pair strobes |
| pcCounterVal | input | 32 | Current prescaled count |
| pcPrescaleVal | input | 32 | Current prescale reload |
| pcPscntrVal | input | 32 | Current prescale down-counter |
| badAccess | output | 1 | High for an access to an unmapped offset |

## Verification
The bench builds two instances on one shared bus, both with CLK_HZ = 200. That gives dividers of 200 and 2, so several 1 Hz ticks and a 100 Hz wrap fit in a few hundred cycles. The first instance has three LEDs, four buttons, three switches, and both optional registers enabled. The second has no LEDs and neither optional register, so every gated-out offset and the masked LED path are seen side by side with the full set. With these small widths the bench sweeps every LED, button and switch pattern, and every word offset of the window for both read decode and ignored writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LED    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_DBG    = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_BTN    = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_CLK1   = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_CLK100 = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_CNT    = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_PRE    = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_PSC    = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_SW     = 12'h028;
  localparam logic [ADDR_W-1:0] OFS_MISC   = 12'h04C;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_LED, SEL_DBG, SEL_BTN, SEL_CLK1, SEL_CLK100,
    SEL_CNT, SEL_PRE, SEL_PSC, SEL_SW, SEL_MISC
  } rdSel_e;

  typedef struct packed {
    logic   rdEn;
    rdSel_e rdSel;
    logic   invalid;
    logic   wrLed;
    logic   wrDbg;
    logic   wrMisc;
    logic   wrClk1;
    logic   wrClk100;
    logic   wrCount;
    logic   wrPresc;
    logic   wrPscnt;
  } ctrlStrobes_t;
endpackage

// File: rtl/sysctl_tick_counter.sv
module sysctl_tick_counter #(
  parameter int DIV = 100
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic [31:0] wdata,
  output logic [31:0] count
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= '0;
      count <= '0;
    end else if (load) begin
      phase <= '0;
      count <= wdata;
    end else if (phase == PH_LAST) begin
      phase <= '0;
      count <= count + 32'd1;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  p_load_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    load |=> count == $past(wdata));

  p_step_by_one_r6: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> (count == $past(count)) || (count == $past(count) + 32'd1));
endmodule

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int NUM_LEDS     = 2,
  parameter bit HAS_DBGCTRL  = 1'b0,
  parameter bit HAS_SWITCHES = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output ctrlStrobes_t      stb
);
  rdSel_e hit;
  logic   wrAcc;

  always_comb begin
    case (paddr)
      OFS_LED:    hit = SEL_LED;
      OFS_DBG:    hit = HAS_DBGCTRL ? SEL_DBG : SEL_NONE;
      OFS_BTN:    hit = SEL_BTN;
      OFS_CLK1:   hit = SEL_CLK1;
      OFS_CLK100: hit = SEL_CLK100;
      OFS_CNT:    hit = SEL_CNT;
      OFS_PRE:    hit = SEL_PRE;
      OFS_PSC:    hit = SEL_PSC;
      OFS_SW:     hit = HAS_SWITCHES ? SEL_SW : SEL_NONE;
      OFS_MISC:   hit = SEL_MISC;
      default:    hit = SEL_NONE;
    endcase
  end

  assign wrAcc = psel && pwrite;

  always_comb begin
    stb          = '0;
    stb.rdEn     = psel && !pwrite;
    stb.rdSel    = hit;
    stb.invalid  = psel && (hit == SEL_NONE);
    stb.wrLed    = wrAcc && (hit == SEL_LED) && (NUM_LEDS > 0);
    stb.wrDbg    = wrAcc && (hit == SEL_DBG);
    stb.wrMisc   = wrAcc && (hit == SEL_MISC);
    stb.wrClk1   = wrAcc && (hit == SEL_CLK1);
    stb.wrClk100 = wrAcc && (hit == SEL_CLK100);
    stb.wrCount  = wrAcc && (hit == SEL_CNT);
    stb.wrPresc  = wrAcc && (hit == SEL_PRE);
    stb.wrPscnt  = wrAcc && (hit == SEL_PSC);
  end

  p_onehot_writes_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrLed, stb.wrDbg, stb.wrMisc, stb.wrClk1, stb.wrClk100,
              stb.wrCount, stb.wrPresc, stb.wrPscnt}));

  p_invalid_no_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.invalid |-> !(stb.wrLed || stb.wrDbg || stb.wrMisc || stb.wrClk1 ||
                      stb.wrClk100 || stb.wrCount || stb.wrPresc || stb.wrPscnt));
endmodule

// File: rtl/sysctl_datapath.sv
module sysctl_datapath
  import sysctl_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int NUM_LEDS     = 2,
  parameter int NUM_BUTTONS  = 4,
  parameter int NUM_SWITCHES = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          stb,
  input  logic [DATA_W-1:0]     pwdata,
  input  logic [NUM_BUTTONS-1:0]  buttons,
  input  logic [NUM_SWITCHES-1:0] switches,
  input  logic [DATA_W-1:0]     pcCounterVal,
  input  logic [DATA_W-1:0]     pcPrescaleVal,
  input  logic [DATA_W-1:0]     pcPscntrVal,
  output logic [(NUM_LEDS > 0 ? NUM_LEDS : 1)-1:0] leds,
  output logic [2:0]            pcWr,
  output logic [DATA_W-1:0]     pcWdata,
  output logic [DATA_W-1:0]     prdata
);
  localparam int LED_W = (NUM_LEDS > 0) ? NUM_LEDS : 1;

  logic [LED_W-1:0]        ledReg;
  logic [DATA_W-1:0]       dbgReg, miscReg, rdVal;
  logic [NUM_BUTTONS-1:0]  btnMeta, btnSync;
  logic [NUM_SWITCHES-1:0] swMeta, swSync;
  logic [1:0]              clkLoad;
  logic [DATA_W-1:0]       clkCnt [2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledReg  <= '0;
      dbgReg  <= '0;
      miscReg <= '0;
      btnMeta <= '0;
      btnSync <= '0;
      swMeta  <= '0;
      swSync  <= '0;
    end else begin
      if (stb.wrLed)  ledReg  <= pwdata[LED_W-1:0];
      if (stb.wrDbg)  dbgReg  <= pwdata;
      if (stb.wrMisc) miscReg <= pwdata;
      btnMeta <= buttons;
      btnSync <= btnMeta;
      swMeta  <= switches;
      swSync  <= swMeta;
    end
  end

  assign clkLoad = {stb.wrClk100, stb.wrClk1};

  for (genvar g = 0; g < 2; g++) begin : g_clk
    localparam int DIV = (g == 0) ? CLK_HZ : CLK_HZ / 100;
    sysctl_tick_counter #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rstN  (rstN),
      .load  (clkLoad[g]),
      .wdata (pwdata),
      .count (clkCnt[g])
    );
  end

  always_comb begin
    case (stb.rdSel)
      SEL_LED:    rdVal = DATA_W'(ledReg);
      SEL_DBG:    rdVal = dbgReg;
      SEL_BTN:    rdVal = DATA_W'(btnSync);
      SEL_CLK1:   rdVal = clkCnt[0];
      SEL_CLK100: rdVal = clkCnt[1];
      SEL_CNT:    rdVal = pcCounterVal;
      SEL_PRE:    rdVal = pcPrescaleVal;
      SEL_PSC:    rdVal = pcPscntrVal;
      SEL_SW:     rdVal = DATA_W'(swSync);
      SEL_MISC:   rdVal = miscReg;
      default:    rdVal = '0;
    endcase
  end

  assign prdata  = stb.rdEn ? rdVal : '0;
  assign leds    = ledReg;
  assign pcWr    = {stb.wrPscnt, stb.wrPresc, stb.wrCount};
  assign pcWdata = pwdata;

  p_invalid_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.invalid |-> prdata == '0);

  if (NUM_LEDS > 0) begin : g_led_chk
    p_led_store_r2: assert property (@(posedge clk) disable iff (!rstN)
      stb.wrLed |=> leds == $past(pwdata[LED_W-1:0]));
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int CLK_HZ       = 50_000_000,
  parameter int NUM_LEDS     = 2,
  parameter int NUM_BUTTONS  = 4,
  parameter int NUM_SWITCHES = 8,
  parameter bit HAS_DBGCTRL  = 1'b0,
  parameter bit HAS_SWITCHES = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    psel,
  input  logic                    pwrite,
  input  logic [11:0]             paddr,
  input  logic [31:0]             pwdata,
  output logic [31:0]             prdata,
  input  logic [NUM_BUTTONS-1:0]  buttons,
  input  logic [NUM_SWITCHES-1:0] switches,
  output logic [(NUM_LEDS > 0 ? NUM_LEDS : 1)-1:0] leds,
  output logic                    pcCounterWr,
  output logic                    pcPrescaleWr,
  output logic                    pcPscntrWr,
  output logic [31:0]             pcWdata,
  input  logic [31:0]             pcCounterVal,
  input  logic [31:0]             pcPrescaleVal,
  input  logic [31:0]             pcPscntrVal,
  output logic                    badAccess
);
  ctrlStrobes_t stb;
  logic [2:0]   pcWr;

  sysctl_ctrl #(
    .NUM_LEDS     (NUM_LEDS),
    .HAS_DBGCTRL  (HAS_DBGCTRL),
    .HAS_SWITCHES (HAS_SWITCHES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .psel   (psel),
    .pwrite (pwrite),
    .paddr  (paddr),
    .stb    (stb)
  );

  sysctl_datapath #(
    .CLK_HZ       (CLK_HZ),
    .NUM_LEDS     (NUM_LEDS),
    .NUM_BUTTONS  (NUM_BUTTONS),
    .NUM_SWITCHES (NUM_SWITCHES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .pwdata        (pwdata),
    .buttons       (buttons),
    .switches      (switches),
    .pcCounterVal  (pcCounterVal),
    .pcPrescaleVal (pcPrescaleVal),
    .pcPscntrVal   (pcPscntrVal),
    .leds          (leds),
    .pcWr          (pcWr),
    .pcWdata       (pcWdata),
    .prdata        (prdata)
  );

  assign pcCounterWr  = pcWr[0];
  assign pcPrescaleWr = pcWr[1];
  assign pcPscntrWr   = pcWr[2];
  assign badAccess    = stb.invalid;

  p_strobe_needs_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pcCounterWr || pcPrescaleWr || pcPscntrWr) |-> (psel && pwrite && !badAccess));
endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;
  localparam int HZ = 200;
  localparam int D1 = HZ;
  localparam int D100 = HZ / 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [3:0] btn = '0;
  logic [2:0] sw = '0;

  logic [31:0] prD, prA, pcWdD, pcWdA;
  logic [2:0]  ledsD;
  logic        ledsA;
  logic        badDo, badAo;
  logic        cWrD, pWrD, sWrD, cWrA, pWrA, sWrA;

  int nChecks = 0, nErr = 0;
  bit finished = 0;
  longint edges = 0;

  logic [31:0] rdD, rdA;
  logic        badD, badA;
  logic [2:0]  strD;
  logic [31:0] wdD;
  longint      eNow, eWr;
  longint      b1 = 0, be1 = 0, b100 = 0, be100 = 0;

  always #10 clk = ~clk;
  always @(posedge clk) edges <= rstN ? edges + 1 : 0;

  sysctl_regbank #(.CLK_HZ(HZ), .NUM_LEDS(3), .NUM_BUTTONS(4), .NUM_SWITCHES(3),
                   .HAS_DBGCTRL(1'b1), .HAS_SWITCHES(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prD), .buttons(btn), .switches(sw), .leds(ledsD),
    .pcCounterWr(cWrD), .pcPrescaleWr(pWrD), .pcPscntrWr(sWrD), .pcWdata(pcWdD),
    .pcCounterVal(32'hC0DE_0018), .pcPrescaleVal(32'h0000_271C),
    .pcPscntrVal(32'h8000_0020), .badAccess(badDo));

  sysctl_regbank #(.CLK_HZ(HZ), .NUM_LEDS(0), .NUM_BUTTONS(2), .NUM_SWITCHES(2),
                   .HAS_DBGCTRL(1'b0), .HAS_SWITCHES(1'b0)) u_alt (
    .clk(clk), .rstN(rstN), .psel(psel), .pwrite(pwrite), .paddr(paddr),
    .pwdata(pwdata), .prdata(prA), .buttons(btn[1:0]), .switches(sw[1:0]),
    .leds(ledsA), .pcCounterWr(cWrA), .pcPrescaleWr(pWrA), .pcPscntrWr(sWrA),
    .pcWdata(pcWdA), .pcCounterVal(32'h1234_5678), .pcPrescaleVal(32'h0BAD_F00D),
    .pcPscntrVal(32'h0000_0055), .badAccess(badAo));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busRd(input logic [11:0] a);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #2;
    rdD = prD; rdA = prA; badD = badDo; badA = badAo; eNow = edges;
    @(negedge clk);
    psel = 1'b0;
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    #2;
    strD = {sWrD, pWrD, cWrD}; wdD = pcWdD; badD = badDo; badA = badAo;
    @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    eWr = edges;
  endtask

  function automatic logic [31:0] expClk(input longint b, input longint be,
                                         input longint e, input int div);
    return 32'(b + (e - be) / div);
  endfunction

  function automatic bit mappedD(input logic [11:0] o);
    return o inside {12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018,
                     12'h01C, 12'h020, 12'h028, 12'h04C};
  endfunction

  function automatic bit mappedA(input logic [11:0] o);
    return o inside {12'h000, 12'h008, 12'h010, 12'h014, 12'h018,
                     12'h01C, 12'h020, 12'h04C};
  endfunction

  task automatic chkClocks(input string tag);
    busRd(12'h010);
    chk(rdD == expClk(b1, be1, eNow, D1), {tag, " R7 1Hz dut"}, rdD, expClk(b1, be1, eNow, D1));
    chk(rdA == expClk(b1, be1, eNow, D1), {tag, " R7 1Hz alt"}, rdA, expClk(b1, be1, eNow, D1));
    busRd(12'h014);
    chk(rdD == expClk(b100, be100, eNow, D100), {tag, " R6 100Hz dut"}, rdD, expClk(b100, be100, eNow, D100));
    chk(rdA == expClk(b100, be100, eNow, D100), {tag, " R6 100Hz alt"}, rdA, expClk(b100, be100, eNow, D100));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    logic [3:0] prevBtn;
    logic [2:0] prevSw;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    chk(ledsD == 3'd0, "R10 leds after reset", 32'(ledsD), 0);
    busRd(12'h000); chk(rdD == 0, "R10 LED reg reset", rdD, 0);
    busRd(12'h004); chk(rdD == 0, "R10 debug reset", rdD, 0);
    busRd(12'h04C); chk(rdD == 0, "R10 control reset", rdD, 0);
    chk(rdA == 0, "R10 control reset alt", rdA, 0);
    chkClocks("R10 reset");

    // R2 LED sweep
    for (int v = 0; v < 16; v++) begin
      busWr(12'h000, 32'(v) | 32'hFFFF_FFF0 & {32{v[0]}});
      chk(ledsD == 3'(v), "R2 leds pins", 32'(ledsD), 32'(v & 7));
      chk(ledsA == 1'b0, "R2 no-led pin", 32'(ledsA), 0);
      busRd(12'h000);
      chk(rdD == 32'(v & 7), "R2 LED readback", rdD, 32'(v & 7));
      chk(rdA == 0 && !badA, "R2 LED zero-count read", rdA, 0);
    end

    // R3 control and debug words
    for (int k = 0; k < 6; k++) begin
      logic [31:0] pat;
      pat = (k == 0) ? 32'hFFFF_FFFF : (32'hA5A5_0001 << k) ^ 32'(k * 97);
      busWr(12'h04C, pat);
      busWr(12'h004, ~pat);
      chk(badD == 1'b0 && badA == 1'b1, "R4 debug write flag", {30'd0, badD, badA}, 32'd1);
      busRd(12'h04C);
      chk(rdD == pat, "R3 control dut", rdD, pat);
      chk(rdA == pat, "R3 control alt", rdA, pat);
      busRd(12'h004);
      chk(rdD == ~pat, "R3 debug dut", rdD, ~pat);
      chk(rdA == 0 && badA, "R4 debug absent alt", rdA, 0);
    end

    // R1/R4 read sweep over every word offset
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] o;
      o = 12'(i * 4);
      busRd(o);
      chk(badD == !mappedD(o), "R1 decode flag dut", 32'(badD), 32'(!mappedD(o)));
      chk(badA == !mappedA(o), "R1 decode flag alt", 32'(badA), 32'(!mappedA(o)));
      if (!mappedD(o)) chk(rdD == 0, "R4 unmapped read dut", rdD, 0);
      if (!mappedA(o)) chk(rdA == 0, "R4 unmapped read alt", rdA, 0);
    end
    foreach (paddr[j]) begin
      busRd(12'h04C ^ (12'h1 << (j % 2)));
      chk(badD && rdD == 0, "R1 unaligned offset", rdD, 0);
    end
    busRd(12'h04C);
    chk(!badD && !badA, "R4 flag low when mapped", {badD, badA}, 0);

    // R4 writes to holes change nothing
    busWr(12'h000, 32'h5);
    busWr(12'h04C, 32'h1357_9BDF);
    busWr(12'h004, 32'h0246_8ACE);
    for (int i = 0; i < 1024; i++) begin
      logic [11:0] o;
      o = 12'(i * 4);
      if (!mappedD(o)) begin
        busWr(o, 32'hFFFF_FFFF);
        if (!badD || strD != 0) chk(0, "R4 hole write", {28'd0, strD, badD}, 1);
      end
    end
    busWr(12'h04E, 32'hFFFF_FFFF);
    chk(badD && strD == 0, "R4 unaligned write", {28'd0, strD, badD}, 1);
    busRd(12'h000); chk(rdD == 5, "R4 LED kept", rdD, 5);
    chk(ledsD == 3'd5, "R4 LED pins kept", 32'(ledsD), 5);
    busRd(12'h04C); chk(rdD == 32'h1357_9BDF, "R4 control kept", rdD, 32'h1357_9BDF);
    busRd(12'h004); chk(rdD == 32'h0246_8ACE, "R4 debug kept", rdD, 32'h0246_8ACE);
    chkClocks("R4 after holes");

    // R5 button sweep with two-edge latency
    prevBtn = 4'd0;
    for (int v = 1; v < 17; v++) begin
      btn = 4'(v);
      busRd(12'h008);
      chk(rdD == 32'(prevBtn), "R5 button 0 edges", rdD, 32'(prevBtn));
      busRd(12'h008);
      chk(rdD == 32'(prevBtn), "R5 button 1 edge", rdD, 32'(prevBtn));
      busRd(12'h008);
      chk(rdD == 32'(btn), "R5 button 2 edges", rdD, 32'(btn));
      chk(rdA == 32'(btn[1:0]), "R5 button alt", rdA, 32'(btn[1:0]));
      prevBtn = btn;
    end
    busWr(12'h008, 32'hFFFF_FFFF);
    busRd(12'h008);
    chk(rdD == 32'(btn) && !badD, "R5 button write ignored", rdD, 32'(btn));

    // R5 switch sweep
    prevSw = 3'd0;
    for (int v = 1; v < 9; v++) begin
      sw = 3'(v);
      busRd(12'h028);
      busRd(12'h028);
      chk(rdD == 32'(prevSw), "R5 switch 1 edge", rdD, 32'(prevSw));
      busRd(12'h028);
      chk(rdD == 32'(sw), "R5 switch 2 edges", rdD, 32'(sw));
      chk(rdA == 0 && badA, "R4 switch absent alt", rdA, 0);
      prevSw = sw;
    end

    // R6/R7 free running
    for (int k = 0; k < 5; k++) begin
      repeat (37) @(negedge clk);
      chkClocks("R6 R7 run");
    end

    // R8 loads and wrap
    busWr(12'h014, 32'hFFFF_FFFF);
    b100 = 32'hFFFF_FFFF; be100 = eWr;
    for (int k = 0; k < 5; k++) begin
      busRd(12'h014);
      chk(rdD == expClk(b100, be100, eNow, D100), "R8 100Hz wrap", rdD, expClk(b100, be100, eNow, D100));
    end
    @(negedge clk);
    busWr(12'h010, 32'd1234);
    b1 = 1234; be1 = eWr;
    for (int k = 0; k < 9; k++) begin
      repeat (61) @(negedge clk);
      chkClocks("R8 after load");
    end
    busWr(12'h010, 32'd7);
    b1 = 7; be1 = eWr;
    repeat (198) @(negedge clk);
    busRd(12'h010);
    chk(rdD == expClk(b1, be1, eNow, D1), "R8 phase restart", rdD, expClk(b1, be1, eNow, D1));
    busRd(12'h010);
    chk(rdD == expClk(b1, be1, eNow, D1), "R8 phase restart tick", rdD, expClk(b1, be1, eNow, D1));

    // R9 prescaled pair bus side
    busRd(12'h018); chk(rdD == 32'hC0DE_0018 && rdA == 32'h1234_5678, "R9 count read", rdD, 32'hC0DE_0018);
    busRd(12'h01C); chk(rdD == 32'h0000_271C && rdA == 32'h0BAD_F00D, "R9 reload read", rdD, 32'h0000_271C);
    busRd(12'h020); chk(rdD == 32'h8000_0020 && rdA == 32'h0000_0055, "R9 down read", rdD, 32'h8000_0020);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] d;
      d = 32'hFACE_0000 + 32'(k);
      busWr(12'(12'h018 + 4 * k), d);
      chk(strD == 3'(1 << k), "R9 strobe select", 32'(strD), 32'(1 << k));
      chk(wdD == d, "R9 strobe data", wdD, d);
      #3;
      chk({sWrD, pWrD, cWrD} == 3'd0, "R9 strobe one cycle", 32'({sWrD, pWrD, cWrD}), 0);
    end
    busWr(12'h04C, 32'h1);
    chk(strD == 0, "R9 no strobe elsewhere", 32'(strD), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule